// File: doc/BRIEF.md
# Scaled Multi-Comparator PWM

This block is a pulse-width modulator built around a 31-bit up-counter. A 4-bit scale value selects which 16-bit window of the counter is compared. Four compare registers are checked against that window in parallel. Each comparator drives one waveform output and one latched interrupt-pending bit. Software programs the block through a small word-addressed register port. It can read and write the counter, read the scaled window, and set up the compare values and the mode bits.

Several mode bits shape the waveforms:
- Continuous mode keeps the counter running. One-shot mode runs it for a single period, then stops it.
- A period option clears the counter as soon as the scaled value reaches compare 0.
- A sticky option keeps pending bits from being cleared.
- Per-comparator gang bits turn an output into a window. The output is high from its own compare point until the next comparator, cyclically, also fires.

Left-aligned and right-aligned waveforms are obtained by choosing the compare values and gang bits.

Top module: `pwm_scaled_top`

## Requirements
- R1: After reset the config word reads 0, the counter reads 0, every compare register reads 0xFFFF, and both `pwm_o` and `irq_o` are 0.
- R2: The scaled value equals counter bits [scale+15:scale], where scale is config bits [3:0]. It is read at word address 2. Writes to word address 2 change no state.
- R3: With its gang bit clear, output k is high exactly while the scaled value is greater than or equal to compare register k. Compare register k is at word address 4+k.
- R4: With gang bit k set (config bit 8+k), output k is high while comparator k fires and comparator (k+1) mod 4 does not.
- R5: While continuous mode (config bit 6) or one-shot mode (config bit 7) is set, the counter (word address 1) rises by one per clock. It wraps from 0x7FFFFFFF to 0. When both modes are clear, the counter holds.
- R6: A bus write to the counter loads it in that cycle and takes precedence over counting.
- R7: With the period option (config bit 5) set and the counter running, the counter loads 0 on the clock after the scaled value reaches or exceeds compare 0. At scale 0 this gives a period of compare0+1 clocks.
- R8: The one-shot bit clears itself on the clock where the counter wraps or is cleared by the period option.
- R9: Pending bit k (config bit 12+k, also `irq_o[k]`) is set on the clock after comparator k fires. It stays set until software writes 0 to that bit. A compare hit in the same cycle as that write wins. Writing 1 sets the bit.
- R10: While the sticky bit (config bit 4) is set at the time of a config write, writing 0 to a set pending bit leaves it set.
- R11: Compare registers hold 16 bits. Bits above 15 are dropped on write and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, with bus_en_i |
| bus_addr_i | input | 3 | Word address: 0 config, 1 counter, 2 scaled value, 4..7 compare 0..3 |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| pwm_o | output | 4 | Waveform outputs, one per comparator |
| irq_o | output | 4 | Interrupt-pending bits, one per comparator |

## Verification
A compare hit and a software write of the config word can land in the same cycle and both act on a pending bit. To provoke this, the bench stops the counter at a value above compare 2. It then writes the config word with the pending field zeroed while comparator 2 is still firing. It judges the outcome by requiring `irq_o[2]` to stay high, and then to fall only when the same write is repeated after the hit has gone. The other same-cycle case is a counter load while the counter is running. This is judged by reading back the loaded value with no increment applied.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned NCMP    = 4;
  localparam int unsigned SCALE_W = 4;
  localparam int unsigned ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADR_CFG = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SCL = 3'd2;
  localparam int unsigned       ADR_CMP_BASE = 4;

  typedef struct packed {
    logic [NCMP-1:0]    gang;
    logic               oneshot;
    logic               cont;
    logic               zero_per;
    logic               sticky;
    logic [SCALE_W-1:0] scale;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W   = 31,
  parameter int unsigned CMP_W   = 16,
  parameter int unsigned SCALE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               zero_en_i,
  input  logic               zero_hit_i,
  input  logic               wr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CMP_W-1:0]   scaled_o,
  output logic               restart_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, shifted;
  logic zrst, wrap;

  assign zrst = run_i & zero_en_i & zero_hit_i & ~wr_i;
  assign wrap = run_i & ~wr_i & (&cnt_q);
  assign restart_o = zrst | wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_i)       cnt_d = wdata_i;
    else if (zrst)  cnt_d = '0;
    else if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign shifted  = cnt_q >> scale_i;
  assign scaled_o = shifted[CMP_W-1:0];
  assign cnt_o    = cnt_q;

  logic unused_hi;
  assign unused_hi = ^shifted[CNT_W-1:CMP_W];

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !wr_i && !zrst |=> cnt_q == $past(cnt_q) + 1'b1);
  // R5
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !wr_i |=> $stable(cnt_q));
  // R6
  count_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));
  // R7
  zero_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && zero_en_i && zero_hit_i && !wr_i |=> cnt_q == '0);
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
  parameter int unsigned NCMP  = 4,
  parameter int unsigned CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMP_W-1:0] scaled_i,
  input  logic [CMP_W-1:0] cmp_i [NCMP],
  input  logic [NCMP-1:0]  gang_i,
  input  logic             sticky_i,
  input  logic             sw_wr_i,
  input  logic [NCMP-1:0]  sw_ip_i,
  output logic [NCMP-1:0]  hit_o,
  output logic [NCMP-1:0]  out_o,
  output logic [NCMP-1:0]  ip_o
);
  logic [NCMP-1:0] hit, ip_q, ip_d;

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    localparam int NX = (i + 1) % NCMP;
    assign hit[i]   = scaled_i >= cmp_i[i];
    assign out_o[i] = gang_i[i] ? (hit[i] & ~hit[NX]) : hit[i];

    // R9
    ip_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[i] |=> ip_q[i]);
    // R10
    ip_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sticky_i && ip_q[i] |=> ip_q[i]);
  end

  // hit wins over a software clear; sticky masks the clear
  always_comb begin
    if (sw_wr_i) ip_d = hit | sw_ip_i | (sticky_i ? ip_q : '0);
    else         ip_d = hit | ip_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ip_q <= '0;
    else         ip_q <= ip_d;
  end

  assign hit_o = hit;
  assign ip_o  = ip_q;
endmodule

// File: rtl/pwm_scaled_top.sv
module pwm_scaled_top
  import pwm_pkg::*;
#(
  parameter int unsigned CMP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic [NCMP-1:0]   pwm_o,
  output logic [NCMP-1:0]   irq_o
);
  localparam int unsigned CNT_W = CMP_W + (2 ** SCALE_W) - 1;

  cfg_t             cfg_q;
  logic [CMP_W-1:0] cmp_q [NCMP];
  logic [CNT_W-1:0] cnt;
  logic [CMP_W-1:0] scaled;
  logic [NCMP-1:0]  hit, ip;
  logic             restart, wr, cfg_wr, cnt_wr;

  assign wr     = bus_en_i & bus_we_i;
  assign cfg_wr = wr & (bus_addr_i == ADR_CFG);
  assign cnt_wr = wr & (bus_addr_i == ADR_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (cfg_wr)  cfg_q <= cfg_t'(bus_wdata_i[CFG_W-1:0]);
    else if (restart) cfg_q.oneshot <= 1'b0;
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_cmpreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_q[k] <= '1;
      else if (wr && bus_addr_i == ADDR_W'(ADR_CMP_BASE + k))
        cmp_q[k] <= bus_wdata_i[CMP_W-1:0];
    end
  end

  pwm_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (cfg_q.cont | cfg_q.oneshot),
    .zero_en_i (cfg_q.zero_per),
    .zero_hit_i(hit[0]),
    .wr_i      (cnt_wr),
    .wdata_i   (bus_wdata_i[CNT_W-1:0]),
    .scale_i   (cfg_q.scale),
    .cnt_o     (cnt),
    .scaled_o  (scaled),
    .restart_o (restart)
  );

  pwm_cmp_bank #(.NCMP(NCMP), .CMP_W(CMP_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scaled_i(scaled),
    .cmp_i   (cmp_q),
    .gang_i  (cfg_q.gang),
    .sticky_i(cfg_q.sticky),
    .sw_wr_i (cfg_wr),
    .sw_ip_i (bus_wdata_i[CFG_W +: NCMP]),
    .hit_o   (hit),
    .out_o   (pwm_o),
    .ip_o    (ip)
  );

  assign irq_o = ip;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADR_CFG: bus_rdata_o = 32'({ip, cfg_q});
      ADR_CNT: bus_rdata_o = 32'(cnt);
      ADR_SCL: bus_rdata_o = 32'(scaled);
      default: if (bus_addr_i[2]) bus_rdata_o = 32'(cmp_q[bus_addr_i[1:0]]);
    endcase
  end

  logic unused_wd;
  assign unused_wd = ^bus_wdata_i;

  // R8
  oneshot_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.oneshot && restart && !cfg_wr |=> !cfg_q.oneshot);
endmodule

// File: tb/pwm_scaled_top_tb_top.sv
`timescale 1ns/1ps
module pwm_scaled_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm, irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwm_scaled_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pwm_o(pwm), .irq_o(irq)
  );

  typedef struct packed {
    logic [3:0]  scale;
    logic [3:0]  gang;
    logic [31:0] cnt;
    logic [15:0] c0, c1, c2, c3;
    logic [3:0]  exp_pwm;
    logic [15:0] exp_scl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd0,  4'b0000, 32'h0000_0100, 16'h0080, 16'h0100, 16'h0101, 16'h0000, 4'b1011, 16'h0100},
    '{4'd4,  4'b0000, 32'h0000_1234, 16'h0123, 16'h0124, 16'h0100, 16'h0200, 4'b0101, 16'h0123},
    '{4'd15, 4'b0000, 32'h7FFF_8000, 16'hFFFF, 16'hFFFE, 16'h8000, 16'h0001, 4'b1111, 16'hFFFF},
    '{4'd0,  4'b0101, 32'h0000_0050, 16'h0040, 16'h0060, 16'h0010, 16'h0050, 4'b1001, 16'h0050},
    '{4'd8,  4'b1000, 32'h0001_2300, 16'h0200, 16'h0200, 16'h0200, 16'h0100, 4'b1000, 16'h0123},
    '{4'd1,  4'b1111, 32'h0000_00C8, 16'd10,   16'd50,   16'd100,  16'd200,  4'b0100, 16'h0064}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, r); chk("R1 cfg", r, 32'h0);
    rd(3'd1, r); chk("R1 count", r, 32'h0);
    rd(3'd4, r); chk("R1 cmp0", r, 32'h0000_FFFF);
    rd(3'd7, r); chk("R1 cmp3", r, 32'h0000_FFFF);
    chk("R1 pwm", {28'h0, pwm}, 32'h0);
    chk("R1 irq", {28'h0, irq}, 32'h0);

    // R2 scaled word ignores writes
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd1, r); chk("R2 count after scaled write", r, 32'h0);
    rd(3'd2, r); chk("R2 scaled after scaled write", r, 32'h0);

    // R11 compare width
    wr(3'd5, 32'hABCD_1234);
    rd(3'd5, r); chk("R11 cmp1 width", r, 32'h0000_1234);

    // R3 R4 R2 vector walk, counter stopped
    for (int v = 0; v < 6; v++) begin
      wr(3'd0, {20'h0, VECS[v].gang, 4'h0, VECS[v].scale});
      wr(3'd4, {16'h0, VECS[v].c0});
      wr(3'd5, {16'h0, VECS[v].c1});
      wr(3'd6, {16'h0, VECS[v].c2});
      wr(3'd7, {16'h0, VECS[v].c3});
      wr(3'd1, VECS[v].cnt);
      chk(VECS[v].gang != 4'h0 ? "R4 gang pwm" : "R3 pwm", {28'h0, pwm}, {28'h0, VECS[v].exp_pwm});
      rd(3'd2, r); chk("R2 scaled", r, {16'h0, VECS[v].exp_scl});
    end

    // R5 continuous counting
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h40);
    idle(10);
    wr(3'd0, 32'h0);
    rd(3'd1, r); chk("R5 count after 11 steps", r, 32'd11);
    wr(3'd1, 32'h7FFF_FFFF);
    wr(3'd0, 32'h40);
    wr(3'd0, 32'h0);
    rd(3'd1, r); chk("R5 wrap", r, 32'h0);

    // R6 load wins over increment
    wr(3'd0, 32'h40);
    wr(3'd1, 32'h100);
    rd(3'd1, r); chk("R6 load while running", r, 32'h100);
    wr(3'd0, 32'h0);
    rd(3'd1, r); chk("R6 count resumes", r, 32'h101);

    // R7 period from compare 0
    wr(3'd4, 32'd4);
    wr(3'd5, 32'hFFFF); wr(3'd6, 32'hFFFF); wr(3'd7, 32'hFFFF);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h60);
    idle(11);
    chk("R9 irq0 after period hit", {28'h0, irq}, 32'h1);
    wr(3'd0, 32'h0);
    rd(3'd1, r); chk("R7 count mod 5", r, 32'd2);

    // R8 one-shot ends on period clear
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hA0);
    idle(2);
    rd(3'd1, r); chk("R8 one-shot running", r, 32'd2);
    rd(3'd0, r); chk("R8 one-shot bit set", {31'h0, r[7]}, 32'h1);
    idle(20);
    rd(3'd1, r); chk("R8 one-shot stopped", r, 32'h0);
    rd(3'd0, r); chk("R8 one-shot bit cleared", {31'h0, r[7]}, 32'h0);

    // R8 one-shot ends on wrap
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h7FFF_FFFE);
    wr(3'd0, 32'h80);
    idle(5);
    rd(3'd1, r); chk("R8 wrap stop count", r, 32'h0);
    rd(3'd0, r); chk("R8 wrap clears bit", {31'h0, r[7]}, 32'h0);

    // R9 pending behaviour
    wr(3'd4, 32'hFFFF); wr(3'd6, 32'h10);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    chk("R9 pending clear", {28'h0, irq}, 32'h0);
    wr(3'd1, 32'h20);
    idle(1);
    chk("R9 pending set by hit", {28'h0, irq}, 32'h4);
    wr(3'd0, 32'h0);
    chk("R9 hit wins over clear", {28'h0, irq}, 32'h4);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    chk("R9 software clear", {28'h0, irq}, 32'h0);

    // R10 sticky
    wr(3'd0, 32'h10);
    wr(3'd1, 32'h20);
    idle(1);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h10);
    chk("R10 sticky holds", {28'h0, irq}, 32'h4);
    chk("R10 output low while pending", {28'h0, pwm}, 32'h0);
    wr(3'd0, 32'h0);
    chk("R10 sticky at write holds", {28'h0, irq}, 32'h4);
    wr(3'd0, 32'h0);
    chk("R9 clear after sticky off", {28'h0, irq}, 32'h0);

    // R9 software set
    wr(3'd0, 32'h1000);
    chk("R9 software set", {28'h0, irq}, 32'h1);
    wr(3'd0, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule